// File: doc/BRIEF.md
# DC-blocking high-pass filter

The block strips a slowly varying offset from a stream of signed audio samples, so that later level detectors read true low-level signals rather than residual digital DC. It keeps a running estimate of the offset for each channel and subtracts that estimate from every incoming sample. The estimate follows the input through a first-order leaky integrator whose speed is set by one signed coefficient, alpha. Samples use a 3.23 fractional format, with three integer bits including the sign. Alpha uses 2.20.

Samples from several channels share one datapath. A channel-ID input selects which stored estimate a sample uses and updates. Each estimate is held in 52 bits, a 3.49 format. This extra precision lets very small alpha values, which give cutoffs of a few hertz, keep moving the estimate even when each step is far below one output LSB. Alpha is loaded through a plain address/data/write-strobe port at register address 180. The conversion from a cutoff frequency to alpha, 1 - exp(-2*pi*fc/fs), is done outside the block.

Top module: `dc_block_hpf`

## Requirements
- R1: After reset, out_valid_o is 0, out_data_o is 0, every channel estimate is 0, and alpha is 411 (2.20), which gives a cutoff of about 2.75 Hz at 44.1 kHz.
- R2: One clock after a cycle with in_valid_i high, out_valid_o is 1 and out_ch_o equals that cycle's in_ch_i. After a cycle with in_valid_i low, out_valid_o is 0.
- R3: out_data_o is computed as follows. Take the input placed on the 49-fraction-bit grid, minus the channel's estimate from before this sample. Floor-divide the result by 2^26, then saturate it to the 26-bit range [-2^25, 2^25-1].
- R4: The channel estimate becomes dc + floor((x*2^26 - dc) * alpha / 2^20), where alpha is read as a signed 22-bit integer.
- R5: When the updated estimate leaves the 52-bit signed range, it is clamped to -2^51 or 2^51-1.
- R6: A sample updates only the estimate of the channel named by in_ch_i. Every other channel's estimate keeps its value.
- R7: A write with wr_en_i high and wr_addr_i equal to 180 loads wr_data_i into alpha. A sample in the same cycle still uses the previous alpha. The new value applies from the next sample on.
- R8: Writes to any address other than 180 leave alpha unchanged.
- R9: While in_valid_i is low, out_data_o holds its value and no estimate changes, whatever is on in_data_i.
- R10: With alpha = 1 LSB and a constant input of 1024 LSBs, each step is far below one 3.23 LSB. Even so, after 4000 samples the output has dropped below the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Sample strobe |
| in_ch_i | input | CH_W | Channel of the sample |
| in_data_i | input | DATA_W | Input sample, 3.23 two's complement |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | COEF_W | Write data, alpha in 2.20 |
| out_valid_o | output | 1 | Output strobe |
| out_ch_o | output | CH_W | Channel of the output sample |
| out_data_o | output | DATA_W | Filtered sample, 3.23 saturated |

## Verification
The bench builds the block with its default parameters: two channels, 26-bit samples, a 22-bit alpha and a 52-bit estimate. At these widths a 128-bit arithmetic model in the bench holds every intermediate product exactly. The bench sweeps 64 input levels across the full 3.23 range, interleaved over both channels, for each of seven alpha values. These include zero, the largest positive value, the most negative value and the reset default. Together they reach both saturation points, the same-cycle write ordering and the sub-LSB convergence case.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
  localparam int unsigned HPF_ALPHA_ADDR = 180;
  localparam int          HPF_ALPHA_RST  = 411;  // ~2.75 Hz at 44.1 kHz
  localparam int unsigned HPF_INT_W      = 3;
  localparam int unsigned HPF_FRAC_X     = 23;
  localparam int unsigned HPF_FRAC_S     = 49;
  localparam int unsigned HPF_COEF_INT   = 2;
  localparam int unsigned HPF_COEF_FRAC  = 20;
endpackage

// File: rtl/hpf_sat.sv
module hpf_sat #(
  parameter int unsigned IN_W  = 27,
  parameter int unsigned OUT_W = 26
) (
  input  logic signed [IN_W-1:0]  d_i,
  output logic signed [OUT_W-1:0] q_o
);
  localparam int unsigned HI_W = IN_W - OUT_W + 1;

  logic [HI_W-1:0] hi;
  assign hi = d_i[IN_W-1 -: HI_W];

  always_comb begin
    if (hi == {HI_W{1'b0}} || hi == {HI_W{1'b1}})
      q_o = d_i[OUT_W-1:0];
    else if (d_i[IN_W-1])
      q_o = {1'b1, {(OUT_W-1){1'b0}}};
    else
      q_o = {1'b0, {(OUT_W-1){1'b1}}};
  end
endmodule

// File: rtl/hpf_coef_reg.sv
module hpf_coef_reg #(
  parameter int unsigned COEF_W     = 22,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned ALPHA_ADDR = 180,
  parameter int          ALPHA_RST  = 411
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [COEF_W-1:0]        wr_data_i,
  output logic signed [COEF_W-1:0] alpha_o
);
  logic hit;
  assign hit = wr_en_i && (wr_addr_i == ADDR_W'(ALPHA_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  alpha_o <= COEF_W'(ALPHA_RST);
    else if (hit) alpha_o <= wr_data_i;
  end
endmodule

// File: rtl/hpf_state_bank.sv
module hpf_state_bank #(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned CH_W    = 1,
  parameter int unsigned STATE_W = 52
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [CH_W-1:0]                  ch_i,
  input  logic signed [STATE_W-1:0]        d_i,
  output logic signed [STATE_W-1:0]        q_o,
  output logic [NUM_CH-1:0][STATE_W-1:0]   all_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel = we_i && (ch_i == CH_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  all_o[i] <= '0;
      else if (sel) all_o[i] <= d_i;
    end
  end

  always_comb begin
    q_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (ch_i == CH_W'(i)) q_o = all_o[i];
  end
endmodule

// File: rtl/hpf_datapath.sv
module hpf_datapath #(
  parameter int unsigned INT_W     = 3,
  parameter int unsigned FRAC_X    = 23,
  parameter int unsigned FRAC_S    = 49,
  parameter int unsigned COEF_W    = 22,
  parameter int unsigned COEF_FRAC = 20
) (
  input  logic signed [INT_W+FRAC_X-1:0] x_i,
  input  logic signed [INT_W+FRAC_S-1:0] dc_i,
  input  logic signed [COEF_W-1:0]       alpha_i,
  output logic signed [INT_W+FRAC_S-1:0] dc_nxt_o,
  output logic signed [INT_W+FRAC_X-1:0] y_o
);
  localparam int unsigned DATA_W  = INT_W + FRAC_X;
  localparam int unsigned STATE_W = INT_W + FRAC_S;
  localparam int unsigned X_SHIFT = FRAC_S - FRAC_X;
  localparam int unsigned DIFF_W  = STATE_W + 1;
  localparam int unsigned PROD_W  = DIFF_W + COEF_W;
  localparam int unsigned INC_W   = PROD_W - COEF_FRAC;
  localparam int unsigned SUM_W   = INC_W + 1;
  localparam int unsigned YW_W    = DIFF_W - X_SHIFT;

  logic signed [DIFF_W-1:0] x_al, dc_ext, diff;
  logic signed [PROD_W-1:0] prod;
  logic signed [INC_W-1:0]  inc;
  logic signed [SUM_W-1:0]  sum;
  logic signed [YW_W-1:0]   y_wide;

  assign x_al   = {x_i[DATA_W-1], x_i, {X_SHIFT{1'b0}}};
  assign dc_ext = {dc_i[STATE_W-1], dc_i};
  assign diff   = x_al - dc_ext;

  // floor scaling by arithmetic shift
  assign prod   = PROD_W'(diff) * PROD_W'(alpha_i);
  assign inc    = INC_W'(prod >>> COEF_FRAC);
  assign sum    = SUM_W'(inc) + SUM_W'(dc_i);
  assign y_wide = YW_W'(diff >>> X_SHIFT);

  hpf_sat #(.IN_W(SUM_W), .OUT_W(STATE_W)) u_sat_state (
    .d_i(sum),
    .q_o(dc_nxt_o)
  );

  hpf_sat #(.IN_W(YW_W), .OUT_W(DATA_W)) u_sat_out (
    .d_i(y_wide),
    .q_o(y_o)
  );
endmodule

// File: rtl/dc_block_hpf.sv
module dc_block_hpf
  import hpf_pkg::*;
#(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned INT_W      = HPF_INT_W,
  parameter int unsigned FRAC_X     = HPF_FRAC_X,
  parameter int unsigned FRAC_S     = HPF_FRAC_S,
  parameter int unsigned COEF_INT   = HPF_COEF_INT,
  parameter int unsigned COEF_FRAC  = HPF_COEF_FRAC,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned ALPHA_ADDR = HPF_ALPHA_ADDR,
  parameter int          ALPHA_RST  = HPF_ALPHA_RST,
  localparam int unsigned CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned DATA_W    = INT_W + FRAC_X,
  localparam int unsigned COEF_W    = COEF_INT + COEF_FRAC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [CH_W-1:0]   in_ch_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [COEF_W-1:0] wr_data_i,
  output logic              out_valid_o,
  output logic [CH_W-1:0]   out_ch_o,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int unsigned STATE_W = INT_W + FRAC_S;

  logic signed [COEF_W-1:0]           alpha_q;
  logic signed [STATE_W-1:0]          dc_cur, dc_nxt;
  logic signed [DATA_W-1:0]           y_nxt;
  logic [NUM_CH-1:0][STATE_W-1:0]     state_all;

  hpf_coef_reg #(
    .COEF_W(COEF_W), .ADDR_W(ADDR_W),
    .ALPHA_ADDR(ALPHA_ADDR), .ALPHA_RST(ALPHA_RST)
  ) u_coef (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .alpha_o(alpha_q)
  );

  hpf_state_bank #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .STATE_W(STATE_W)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(in_valid_i), .ch_i(in_ch_i),
    .d_i(dc_nxt), .q_o(dc_cur), .all_o(state_all)
  );

  hpf_datapath #(
    .INT_W(INT_W), .FRAC_X(FRAC_X), .FRAC_S(FRAC_S),
    .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)
  ) u_dp (
    .x_i(in_data_i), .dc_i(dc_cur), .alpha_i(alpha_q),
    .dc_nxt_o(dc_nxt), .y_o(y_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_ch_o    <= '0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        out_ch_o   <= in_ch_i;
        out_data_o <= y_nxt;
      end
    end
  end
endmodule

// File: rtl/hpf_checker.sv
module hpf_checker #(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned CH_W       = 1,
  parameter int unsigned DATA_W     = 26,
  parameter int unsigned COEF_W     = 22,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned STATE_W    = 52,
  parameter int unsigned ALPHA_ADDR = 180
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           in_valid_i,
  input logic [CH_W-1:0]                in_ch_i,
  input logic                           wr_en_i,
  input logic [ADDR_W-1:0]              wr_addr_i,
  input logic [COEF_W-1:0]              wr_data_i,
  input logic                           out_valid_o,
  input logic [CH_W-1:0]                out_ch_o,
  input logic [DATA_W-1:0]              out_data_o,
  input logic [COEF_W-1:0]              alpha_i,
  input logic [NUM_CH-1:0][STATE_W-1:0] state_all_i
);
  logic hit;
  assign hit = wr_en_i && (wr_addr_i == ADDR_W'(ALPHA_ADDR));

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r2_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  a_r2_ch_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_ch_o == $past(in_ch_i));
  a_r7_alpha_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> alpha_i == $past(wr_data_i));
  a_r8_alpha_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(alpha_i));
  a_r9_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_data_o));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    a_r6_other_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(in_valid_i && in_ch_i == CH_W'(i)) |=> $stable(state_all_i[i]));
  end
endmodule

bind dc_block_hpf hpf_checker #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .COEF_W(COEF_W),
  .ADDR_W(ADDR_W), .STATE_W(STATE_W), .ALPHA_ADDR(ALPHA_ADDR)
) u_hpf_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ch_i(in_ch_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .out_valid_o(out_valid_o), .out_ch_o(out_ch_o), .out_data_o(out_data_o),
  .alpha_i(alpha_q), .state_all_i(state_all)
);

// File: tb/tb_dc_block_hpf.sv
module tb_dc_block_hpf;
  localparam int DATA_W = 26;
  localparam int COEF_W = 22;
  localparam int STATE_W = 52;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [0:0]        in_ch = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic              wr_en = 1'b0;
  logic [7:0]        wr_addr = '0;
  logic [COEF_W-1:0] wr_data = '0;
  logic              out_valid;
  logic [0:0]        out_ch;
  logic [DATA_W-1:0] out_data;

  dc_block_hpf dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ch_i(in_ch),
    .in_data_i(in_data), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .out_valid_o(out_valid), .out_ch_o(out_ch),
    .out_data_o(out_data)
  );

  int checks = 0;
  int errors = 0;
  logic signed [127:0] dc_ref [2];
  logic signed [127:0] alpha_ref;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic signed [127:0] clamp(logic signed [127:0] v, int w);
    logic signed [127:0] hi, lo;
    hi = (128'sd1 <<< (w - 1)) - 128'sd1;
    lo = -(128'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint sval(logic [DATA_W-1:0] v);
    logic signed [DATA_W-1:0] s;
    s = v;
    return longint'(s);
  endfunction

  // model update, returns expected output
  function automatic longint model(int ch, logic signed [DATA_W-1:0] x);
    logic signed [127:0] xw, d, y;
    xw = x;
    d = (xw <<< 26) - dc_ref[ch];
    y = clamp(d >>> 26, DATA_W);
    dc_ref[ch] = clamp(dc_ref[ch] + ((d * alpha_ref) >>> 20), STATE_W);
    return longint'(y);
  endfunction

  task automatic send(int ch, logic signed [DATA_W-1:0] x, string req);
    longint ye;
    @(negedge clk);
    in_valid = 1'b1; in_ch = 1'(ch); in_data = x;
    @(negedge clk);
    in_valid = 1'b0; in_data = 26'h2AAAAAA;
    ye = model(ch, x);
    chk({req, " R2 valid"}, longint'(out_valid), 1);
    chk({req, " R2 ch"}, longint'(out_ch), longint'(ch));
    chk(req, sval(out_data), ye);
  endtask

  task automatic write(int addr, logic signed [COEF_W-1:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(addr); wr_data = a;
    @(negedge clk);
    wr_en = 1'b0;
    if (addr == 180) alpha_ref = a;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    dc_ref[0] = '0; dc_ref[1] = '0; alpha_ref = 128'sd411;
    @(negedge clk);
    chk("R1 reset valid", longint'(out_valid), 0);
    chk("R1 reset data", sval(out_data), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic signed [COEF_W-1:0] alphas [7];
    longint ylast;
    alphas[0] = 22'sd411;       alphas[1] = 22'sd1;
    alphas[2] = 22'sh100000;    alphas[3] = 22'sh07FFFF;
    alphas[4] = 22'sh1FFFFF;    alphas[5] = 22'sh200000;
    alphas[6] = 22'sd0;
    dc_ref[0] = '0; dc_ref[1] = '0; alpha_ref = 128'sd411;
    repeat (3) @(negedge clk);
    do_reset();

    // R1 default alpha: first sample passes through, then 411 LSB tracking
    send(0, 26'sd1000000, "R1 R3 first");
    send(0, 26'sd1000000, "R1 R4 default alpha");
    send(1, -26'sd5000000, "R6 ch1 fresh");

    // R9 idle cycles with junk input
    ylast = sval(out_data);
    @(negedge clk); in_data = 26'h1234567;
    repeat (5) @(negedge clk);
    chk("R9 idle valid", longint'(out_valid), 0);
    chk("R9 idle hold", sval(out_data), ylast);
    send(0, 26'sd1000000, "R9 state kept");

    // R8 other addresses ignored
    write(181, 22'sh100000);
    write(179, 22'sh100000);
    write(0, 22'sh100000);
    write(255, 22'sh100000);
    send(1, 26'sd300000, "R8 ignored write");

    // R7 same-cycle write uses old alpha
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'd180; wr_data = 22'sh100000;
    in_valid = 1'b1; in_ch = 1'b0; in_data = 26'sd2000000;
    @(negedge clk);
    wr_en = 1'b0; in_valid = 1'b0;
    chk("R7 old alpha", sval(out_data), model(0, 26'sd2000000));
    alpha_ref = 128'sh100000;
    send(0, 26'sd2000000, "R7 new alpha");
    send(0, 26'sd2000000, "R7 dc equals x");

    // R3 output saturation, R5 state saturation
    send(0, -26'sd33554432, "R4 full step");
    send(0, 26'sd33554431, "R3 sat high");
    send(0, -26'sd33554432, "R3 sat low");
    write(180, 22'sh1FFFFF);
    send(0, 26'sd33554431, "R5 state sat");
    send(0, -26'sd33554432, "R5 state sat low");
    send(0, 26'sd0, "R5 after sat");

    // sweep alpha x level across both channels
    for (int a = 0; a < 7; a++) begin
      write(180, alphas[a]);
      for (int k = 0; k < 64; k++) begin
        send(k % 2, 26'(-33554432 + k * 1048576 + k * 37), "R4 sweep");
      end
    end

    // R10 sub-LSB convergence
    do_reset();
    write(180, 22'sd1);
    for (int n = 0; n < 4000; n++) send(1, 26'sd1024, "R10 track");
    checks++;
    if (!(sval(out_data) < 1024)) begin
      errors++;
      $display("FAIL R10 actual %0d expected below 1024", sval(out_data));
    end
    send(0, 26'sd777, "R6 ch0 untouched");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule